// File: doc/BRIEF.md
# Packet-Granular Isochronous Byte Stream Port

This block connects an external byte-wide streaming device to a shared packet buffer that feeds an isochronous link. Everything runs on the stream clock. A direction input picks the buffer's role. When it is low, the external device writes bytes into the buffer, and the link drains them one packet at a time. When it is high, the link fills the buffer with packets, and the external device reads them out whole. Each received packet carries a CRC-bad flag.

The permission output always works on whole packets. In transmit it stays asserted while there is room, and it falls one byte before the buffer is full. After a bus-reset event it also falls at the next packet boundary. In receive it signals that a complete packet is waiting, and it drops for one cycle after each packet has been read.

A direction change clears the buffer. A change to receive is held off until every complete transmit packet has left. Packet length for transmit comes from a configuration input. For received packets, a small tag queue records each packet's length and CRC flag.

Top module: `iso_stream_port`

## Requirements
- R1: While reset is held with the direction input high, `grant`, `data_oe`, `crc_err` and `tx_pkt_ready` are all 0.
- R2: When `dir_rx` is 0 while in receive, the port enters transmit at the next clock edge and clears the buffer. Any received packets are lost.
- R3: When `dir_rx` is 1 while in transmit, `grant` is 0 and stream bytes are ignored. The port stays in transmit while `tx_pkt_ready` is 1. It enters receive one edge after the last complete packet has been popped, and any partial packet is discarded.
- R4: In transmit, each cycle with `valid`=1 and the write accepted stores `data_in`. The link pops bytes through `tx_pop`/`tx_byte` in the same order they were written.
- R5: In transmit, `grant` is 1 while the buffer holds at most DEPTH-2 bytes and 0 from DEPTH-1 on. One more byte is still accepted at DEPTH-1, and writes to a full buffer are dropped.
- R6: `tx_pkt_ready` is 1 while at least one complete packet of `pkt_len_cfg` bytes is buffered. A packet stops counting on the pop of its last byte. A pop with no complete packet buffered is ignored.
- R7: After a `bus_reset` pulse in transmit, `grant` stays 1 until the packet being written completes. It then goes to 0 and written bytes are ignored. `grant` returns to 1 one edge after the next packet has been fully popped.
- R8: In receive, `grant` is 1 only while a complete packet is buffered. It is 0 for exactly one cycle after the last byte of a packet is read, then 1 again if another packet remains.
- R9: In receive, `data_oe` equals `valid` AND `grant`. `data_out` shows the head byte, and it advances at each edge where `data_oe` is 1.
- R10: `crc_err` is 1 exactly when `data_oe` is 1 during the readout of a packet pushed with `rx_crc_bad`=1 on its last byte.
- R11: Link pushes (`rx_push`) are ignored in transmit, and stream bytes and `tx_pop` have no effect in receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Active-low reset |
| dir_rx | input | 1 | 0 = transmit, 1 = receive |
| pkt_len_cfg | input | CW | Transmit packet length in bytes (at least 1) |
| bus_reset | input | 1 | One-cycle bus-reset event |
| grant | output | 1 | Access permission to the external device |
| valid | input | 1 | Byte strobe from the external device |
| data_in | input | 8 | Stream byte in (transmit) |
| data_out | output | 8 | Stream byte out (receive) |
| data_oe | output | 1 | Drive enable for data_out; bus released when 0 |
| crc_err | output | 1 | CRC-bad flag for the packet being read |
| tx_pop | input | 1 | Link consumes one transmit byte |
| tx_byte | output | 8 | Head byte for the link |
| tx_pkt_ready | output | 1 | At least one complete transmit packet buffered |
| rx_push | input | 1 | Link writes one received byte |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | Marks the last byte of a received packet |
| rx_crc_bad | input | 1 | CRC-bad flag, sampled with rx_eop |

## Verification
The assertions assume that the link never pushes a received byte into a full buffer or an end of packet into a full tag queue. They also assume that `pkt_len_cfg` is non-zero and only changes while the buffer is empty. The stimulus respects these limits by keeping the received traffic well below the buffer and tag depth. It also sets the packet length only between drained phases. Random byte values and random `valid` gaps are mixed with directed cases: filling the buffer to the brim, a bus reset in the middle of a packet, and a direction change with packets still pending.

// File: rtl/iso_pkg.sv
`timescale 1ns/1ps
package iso_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  // permission in transmit: at least two free byte slots
  function automatic logic room_for_grant(logic [31:0] fill, logic [31:0] depth);
    return (fill + 32'd1) < depth;
  endfunction

  // the byte at position pos closes a packet of len bytes
  function automatic logic closes_packet(logic [31:0] pos, logic [31:0] len);
    return (pos + 32'd1) == len;
  endfunction
endpackage

// File: rtl/iso_byte_fifo.sv
`timescale 1ns/1ps
module iso_byte_fifo #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [7:0]    wdata,
  input  logic          rd,
  output logic [7:0]    rdata,
  output logic [CW-1:0] fill
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, we, re;

  assign full  = fill == CW'(DEPTH);
  assign empty = fill == '0;
  assign we    = wr && !full && !clr;
  assign re    = rd && !empty && !clr;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (we) wptr <= wptr + AW'(1);
      if (re) rptr <= rptr + AW'(1);
      case ({we, re})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  // R5: the controller never offers a byte to a full buffer as a real write
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |-> !full);
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !clr) |-> !empty);
endmodule

// File: rtl/iso_tag_queue.sv
`timescale 1ns/1ps
module iso_tag_queue #(
  parameter int DEPTH = 32,
  parameter int LW    = 11,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          push_crc,
  input  logic          pop,
  output logic [LW-1:0] head_len,
  output logic          head_crc,
  output logic          nonempty
);
  logic [LW-1:0] len_mem [DEPTH];
  logic          crc_mem [DEPTH];
  logic [TW-1:0] wptr, rptr;
  logic [TW:0]   count;

  assign nonempty = count != '0;
  assign head_len = len_mem[rptr];
  assign head_crc = crc_mem[rptr];

  always_ff @(posedge clk) begin
    if (push && !clr) begin
      len_mem[wptr] <= push_len;
      crc_mem[wptr] <= push_crc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push) wptr <= wptr + TW'(1);
      if (pop)  rptr <= rptr + TW'(1);
      case ({push, pop})
        2'b10:   count <= count + (TW+1)'(1);
        2'b01:   count <= count - (TW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  // R8: link never reports more complete packets than the tag queue holds
  a_r8_tag_room: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> (count != (TW+1)'(DEPTH)));
  a_r8_pop_needs_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> nonempty);
endmodule

// File: rtl/iso_stream_port.sv
`timescale 1ns/1ps
module iso_stream_port
  import iso_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int TAG_DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rx,
  input  logic [CW-1:0] pkt_len_cfg,
  input  logic          bus_reset,
  output logic          grant,
  input  logic          valid,
  input  logic [7:0]    data_in,
  output logic [7:0]    data_out,
  output logic          data_oe,
  output logic          crc_err,
  input  logic          tx_pop,
  output logic [7:0]    tx_byte,
  output logic          tx_pkt_ready,
  input  logic          rx_push,
  input  logic [7:0]    rx_byte,
  input  logic          rx_eop,
  input  logic          rx_crc_bad
);
  dir_e          mode;
  logic [CW-1:0] fill, wr_pos, rd_pos, tx_pkts, rx_len_acc;
  logic [CW-1:0] head_len;
  logic          head_crc, tag_nonempty;
  logic          stall, pend, gap;
  logic [7:0]    fifo_rdata;

  // named internal events
  logic in_tx, in_rx, sw_go, clr;
  logic tx_wr, tx_wr_last, tx_rd, tx_rd_last, boundary, arm;
  logic rx_wr, rx_eop_ev, rx_grant, rx_rd, rx_rd_last;

  assign in_tx = mode == DIR_TX;
  assign in_rx = mode == DIR_RX;
  assign sw_go = (in_rx && !dir_rx) || (in_tx && dir_rx && tx_pkts == '0);
  assign clr   = sw_go;

  // transmit side
  assign tx_wr      = in_tx && !dir_rx && !stall && valid && (fill != CW'(DEPTH)) && !sw_go;
  assign tx_wr_last = tx_wr && closes_packet(32'(wr_pos), 32'(pkt_len_cfg));
  assign tx_rd      = in_tx && tx_pop && (tx_pkts != '0) && !sw_go;
  assign tx_rd_last = tx_rd && closes_packet(32'(rd_pos), 32'(pkt_len_cfg));
  assign boundary   = (wr_pos == '0 && !tx_wr) || tx_wr_last;
  assign arm        = in_tx && (pend || bus_reset);

  // receive side
  assign rx_wr      = in_rx && rx_push && (fill != CW'(DEPTH)) && !sw_go;
  assign rx_eop_ev  = rx_wr && rx_eop;
  assign rx_grant   = in_rx && dir_rx && tag_nonempty && !gap;
  assign rx_rd      = rx_grant && valid;
  assign rx_rd_last = rx_rd && closes_packet(32'(rd_pos), 32'(head_len));

  assign grant = in_tx ? (!dir_rx && !stall && room_for_grant(32'(fill), 32'(DEPTH)))
                       : rx_grant;
  assign data_oe      = rx_rd;
  assign data_out     = fifo_rdata;
  assign crc_err      = rx_rd && head_crc;
  assign tx_byte      = fifo_rdata;
  assign tx_pkt_ready = in_tx && (tx_pkts != '0);

  iso_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .wr    (tx_wr || rx_wr),
    .wdata (in_tx ? data_in : rx_byte),
    .rd    (tx_rd || rx_rd),
    .rdata (fifo_rdata),
    .fill  (fill)
  );

  iso_tag_queue #(.DEPTH(TAG_DEPTH), .LW(CW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .push     (rx_eop_ev),
    .push_len (rx_len_acc + CW'(1)),
    .push_crc (rx_crc_bad),
    .pop      (rx_rd_last),
    .head_len (head_len),
    .head_crc (head_crc),
    .nonempty (tag_nonempty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= DIR_RX;
    end else if (sw_go) begin
      mode <= dir_rx ? DIR_RX : DIR_TX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos <= '0; rd_pos <= '0; tx_pkts <= '0; rx_len_acc <= '0;
      stall <= 1'b0; pend <= 1'b0; gap <= 1'b0;
    end else if (clr) begin
      wr_pos <= '0; rd_pos <= '0; tx_pkts <= '0; rx_len_acc <= '0;
      stall <= 1'b0; pend <= 1'b0; gap <= 1'b0;
    end else begin
      if (tx_wr) wr_pos <= tx_wr_last ? '0 : wr_pos + CW'(1);
      if (tx_rd)      rd_pos <= tx_rd_last ? '0 : rd_pos + CW'(1);
      else if (rx_rd) rd_pos <= rx_rd_last ? '0 : rd_pos + CW'(1);
      case ({tx_wr_last, tx_rd_last})
        2'b10:   tx_pkts <= tx_pkts + CW'(1);
        2'b01:   tx_pkts <= tx_pkts - CW'(1);
        default: tx_pkts <= tx_pkts;
      endcase
      if (rx_wr) rx_len_acc <= rx_eop ? '0 : rx_len_acc + CW'(1);
      // bus reset: wait for a packet boundary, then hold until one packet leaves
      if (arm && boundary) begin
        stall <= 1'b1;
        pend  <= 1'b0;
      end else begin
        pend <= arm;
        if (stall && tx_rd_last) stall <= 1'b0;
      end
      gap <= rx_rd_last;
    end
  end

  a_r9_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (valid && dir_rx));
  a_r10_crc_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> data_oe);
  a_r5_grant_low_near_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && fill >= CW'(DEPTH - 1)) |-> !grant);
  a_r8_gap_after_packet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_last |=> !grant);
  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !grant);
  a_r2_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> (fill == '0));
  a_r3_rx_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rx && $past(in_tx)) |-> $past(!tx_pkt_ready));
endmodule

// File: tb/test_iso_stream_port.sv
`timescale 1ns/1ps
module test_iso_stream_port;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_rx = 1'b1, bus_reset = 1'b0, valid = 1'b0, tx_pop = 1'b0;
  logic rx_push = 1'b0, rx_eop = 1'b0, rx_crc_bad = 1'b0;
  logic [CW-1:0] pkt_len_cfg = CW'(4);
  logic [7:0] data_in = '0, rx_byte = '0;
  logic grant, data_oe, crc_err, tx_pkt_ready;
  logic [7:0] data_out, tx_byte;

  int checks = 0, fails = 0;
  byte unsigned exp_q[$];
  int  len_q[$];
  bit  crc_q[$];

  iso_stream_port #(.DEPTH(DEPTH), .TAG_DEPTH(8)) i_iso_stream_port (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .pkt_len_cfg(pkt_len_cfg),
    .bus_reset(bus_reset), .grant(grant), .valid(valid), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .crc_err(crc_err), .tx_pop(tx_pop),
    .tx_byte(tx_byte), .tx_pkt_ready(tx_pkt_ready), .rx_push(rx_push),
    .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_crc_bad(rx_crc_bad));

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // bench-side restatement of the transmit permission rule
  function automatic bit exp_tx_grant(int fill);
    return fill <= DEPTH - 2;
  endfunction

  task automatic push_pkt(int len, bit bad, byte unsigned base);
    for (int i = 0; i < len; i++) begin
      rx_push = 1; rx_byte = base + 8'(i); rx_eop = (i == len - 1); rx_crc_bad = bad;
      exp_q.push_back(base + 8'(i));
      step();
    end
    rx_push = 0; rx_eop = 0; rx_crc_bad = 0;
    len_q.push_back(len); crc_q.push_back(bad);
  endtask

  task automatic read_pkt(bit gaps);
    int len = len_q.pop_front();
    bit bad = crc_q.pop_front();
    #1 chk(grant == 1, "R8 grant with packet", grant, 1);
    for (int i = 0; i < len; i++) begin
      byte unsigned e = exp_q.pop_front();
      if (gaps && ($urandom % 3 == 0)) begin
        valid = 0; #1;
        chk(data_oe == 0, "R9 oe idle", data_oe, 0);
        chk(data_out == e, "R9 head held", data_out, e);
        step();
      end
      valid = 1; #1;
      chk(data_oe == 1, "R9 oe on valid", data_oe, 1);
      chk(data_out == e, "R9 data order", data_out, e);
      chk(crc_err == bad, "R10 crc flag", crc_err, bad);
      step();
    end
    valid = 0; #1;
    chk(grant == 0, "R8 one-cycle drop", grant, 0);
    chk(crc_err == 0, "R10 crc idle", crc_err, 0);
    step(); #1;
    chk(grant == (len_q.size() != 0), "R8 reassert", grant, len_q.size() != 0);
  endtask

  task automatic wr_byte(byte unsigned b);
    valid = 1; data_in = b; step(); valid = 0;
  endtask

  task automatic pop_chk(byte unsigned e, string req);
    tx_pop = 1; #1;
    chk(tx_byte == e, req, tx_byte, e);
    step(); tx_pop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    byte unsigned b;
    repeat (3) step();
    #1;
    chk(grant == 0, "R1 grant", grant, 0);
    chk(data_oe == 0, "R1 oe", data_oe, 0);
    chk(crc_err == 0, "R1 crc", crc_err, 0);
    chk(tx_pkt_ready == 0, "R1 ready", tx_pkt_ready, 0);
    rst_n = 1; step();

    // receive, directed
    rx_push = 1; rx_byte = 8'h10; step(); rx_push = 0; #1;
    chk(grant == 0, "R8 no grant on partial", grant, 0);
    exp_q.push_back(8'h10);
    push_pkt(4, 0, 8'h11);
    len_q[0] = 5;
    push_pkt(3, 1, 8'hA0);
    read_pkt(0);
    read_pkt(1);
    // R11: stream inputs and tx_pop ignored in receive
    valid = 1; tx_pop = 1; data_in = 8'h55; #1;
    chk(data_oe == 0, "R11 oe without packet", data_oe, 0);
    chk(tx_pkt_ready == 0, "R11 ready in rx", tx_pkt_ready, 0);
    step(); valid = 0; tx_pop = 0;

    // receive, random
    for (int p = 0; p < 6; p++) push_pkt(1 + $urandom % 6, 1'($urandom), 8'($urandom));
    while (len_q.size() != 0) read_pkt(1);

    // R2: switch to transmit with a received packet pending
    push_pkt(2, 0, 8'hC0);
    len_q.delete(); crc_q.delete(); exp_q.delete();
    dir_rx = 0; step(); #1;
    chk(grant == 1, "R2 tx grant", grant, 1);
    chk(tx_pkt_ready == 0, "R2 cleared", tx_pkt_ready, 0);

    // R11: link push ignored in transmit
    rx_push = 1; rx_eop = 1; step(); rx_push = 0; rx_eop = 0; #1;
    chk(tx_pkt_ready == 0, "R11 push ignored in tx", tx_pkt_ready, 0);

    // R4/R6: transmit, random bytes with gaps
    pkt_len_cfg = CW'(4);
    for (int i = 0; i < 10; i++) begin
      b = 8'($urandom);
      if ($urandom % 2 == 0) step();
      wr_byte(b); exp_q.push_back(b);
      if (i == 2) begin #1 chk(tx_pkt_ready == 0, "R6 not yet", tx_pkt_ready, 0); end
      if (i == 3) begin #1 chk(tx_pkt_ready == 1, "R6 ready", tx_pkt_ready, 1); end
    end
    for (int i = 0; i < 8; i++) pop_chk(exp_q.pop_front(), "R4 order");
    #1 chk(tx_pkt_ready == 0, "R6 drained", tx_pkt_ready, 0);
    tx_pop = 1; step(); tx_pop = 0;   // no complete packet: ignored

    // R7: bus reset during a partial packet
    bus_reset = 1; step(); bus_reset = 0; #1;
    chk(grant == 1, "R7 grant until boundary", grant, 1);
    wr_byte(8'h71); exp_q.push_back(8'h71);
    wr_byte(8'h72); exp_q.push_back(8'h72);
    #1 chk(grant == 0, "R7 stalled", grant, 0);
    for (int i = 0; i < 4; i++) wr_byte(8'hEE);
    #1 chk(tx_pkt_ready == 1, "R7 ready", tx_pkt_ready, 1);
    for (int i = 0; i < 4; i++) begin
      if (i == 3) begin #1 chk(grant == 0, "R7 still stalled", grant, 0); end
      pop_chk(exp_q.pop_front(), "R7 order");
    end
    #1;
    chk(grant == 1, "R7 resumed", grant, 1);
    chk(tx_pkt_ready == 0, "R7 stalled bytes dropped", tx_pkt_ready, 0);

    // R5: fill to the brim
    pkt_len_cfg = CW'(8);
    n = 0;
    forever begin
      valid = 1; data_in = 8'(n); #1;
      if (!grant) break;
      if (!exp_tx_grant(n)) chk(0, "R5 grant too long", n, DEPTH - 2);
      step(); n++;
    end
    chk(n == DEPTH - 1, "R5 grant drop point", n, DEPTH - 1);
    step();
    data_in = 8'hFF; step(); valid = 0;
    for (int i = 0; i < DEPTH; i++) pop_chk(8'(i), "R5 full content");
    #1 chk(tx_pkt_ready == 0, "R5 overflow dropped", tx_pkt_ready, 0);

    // R3: deferred switch to receive
    for (int i = 0; i < 11; i++) wr_byte(8'(8'h30 + i));
    dir_rx = 1; #1;
    chk(grant == 0, "R3 grant off pending", grant, 0);
    step(); #1;
    chk(tx_pkt_ready == 1, "R3 still transmit", tx_pkt_ready, 1);
    wr_byte(8'h99);
    for (int i = 0; i < 8; i++) pop_chk(8'(8'h30 + i), "R3 drain order");
    step(); #1;
    chk(grant == 0, "R3 receive empty", grant, 0);
    chk(tx_pkt_ready == 0, "R3 left transmit", tx_pkt_ready, 0);
    exp_q.delete();
    push_pkt(2, 0, 8'h5A);
    read_pkt(0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule